// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the instruction fetch address for a small accumulator-style processor core. It keeps a 13-bit program counter that can step forward, jump or call to a target inside a 2K-word page, be loaded through its low byte, or be restored from a return stack. The upper five counter bits are never loaded straight from an operand. They come from a separate 5-bit page latch, which is copied into the counter when the low byte is written, and whose two top bits pick the page on jumps and calls.

An 8-deep, 13-bit return stack saves the return address on calls and the interrupted address on interrupt entry. Any return operation pops it and restores the whole counter. The stack is a ring: once full, a further push overwrites the oldest entry and nothing reports this. Stack traffic never touches the page latch. The core's decoder drives one strobe per operation. Fetch logic uses the full counter, and a narrower memory address whose upper bits drop away, so that an access past the end of the fitted memory wraps.

Top module: `fetch_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the counter, the page latch and the stack pointer are zero, so `fetch_addr_o` reads 0000h. A return taken straight after reset restores 0000h.
- R2: `step_i` alone adds one to the counter modulo 2^13, so 1FFFh is followed by 0000h.
- R3: `lo_wr_i` loads the counter with the page latch in bits 12:8 and `lo_wdata_i` in bits 7:0. `pc_lo_o` always shows counter bits 7:0.
- R4: `jump_i` loads counter bits 10:0 from `target_i` and bits 12:11 from page latch bits 4:3.
- R5: `call_i` pushes the counter plus one (modulo 2^13) and then loads the counter in the same way as a jump.
- R6: `ret_i` pops the most recent entry and loads all 13 counter bits from it.
- R7: `irq_i` pushes the current counter value and loads 0004h.
- R8: The page latch changes only on `latch_wr_i`, which loads `latch_wdata_i`. Pushes and pops leave it unchanged.
- R9: The stack is a ring of 8 entries. After nine pushes without a pop, the first eight pops return pushes nine down to two, and a ninth pop returns push nine again.
- R10: `mem_addr_o` equals the low MEM_AW bits of the counter (default 10), so addresses past the fitted memory wrap.
- R11: When strobes coincide, one operation is taken, in this order: interrupt, call, jump, return, low-byte write, step. A latch write still happens alongside any of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Sequential increment |
| jump_i | input | 1 | In-page jump |
| call_i | input | 1 | In-page call with push |
| ret_i | input | 1 | Return, pops the stack |
| irq_i | input | 1 | Interrupt entry |
| lo_wr_i | input | 1 | Write the low counter byte |
| lo_wdata_i | input | 8 | Low byte value |
| latch_wr_i | input | 1 | Write the page latch |
| latch_wdata_i | input | 5 | Page latch value |
| target_i | input | 11 | Jump and call target within the page |
| fetch_addr_o | output | 13 | Full program counter |
| mem_addr_o | output | 10 | Counter wrapped to the fitted memory size |
| pc_lo_o | output | 8 | Readable low counter byte |

## Verification
Every operation has its effect on the clock edge that samples its strobe, so the counter, the memory address and the low byte are due one cycle after the strobe. The bench drives strobes on falling edges and samples on the next falling edge, after exactly one rising edge. A pushed value is only seen once a later return brings it back. The stack and latch checks therefore compare the address seen after a return, or after a low-byte write, against a model that tracks pushes, pops and latch writes in order.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int unsigned DEF_PC_W    = 13;
    localparam int unsigned DEF_TGT_W   = 11;
    localparam int unsigned DEF_LOW_W   = 8;
    localparam int unsigned DEF_DEPTH   = 8;
    localparam int unsigned DEF_MEM_AW  = 10;
    localparam int unsigned DEF_RST_VEC = 0;
    localparam int unsigned DEF_IRQ_VEC = 4;

    // one counter operation per cycle, chosen by priority
    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_STEP = 3'd1,
        OP_LOWR = 3'd2,
        OP_RET  = 3'd3,
        OP_JUMP = 3'd4,
        OP_CALL = 3'd5,
        OP_IRQ  = 3'd6
    } pc_op_e;

    typedef struct packed {
        logic irq;
        logic call;
        logic jump;
        logic ret;
        logic lowr;
        logic step;
    } strobes_t;

    function automatic logic op_pushes(pc_op_e op);
        return (op == OP_CALL) || (op == OP_IRQ);
    endfunction

    function automatic logic op_pops(pc_op_e op);
        return op == OP_RET;
    endfunction

endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  strobes_t req,
    output pc_op_e   op
);
    always_comb begin
        if (req.irq)       op = OP_IRQ;
        else if (req.call) op = OP_CALL;
        else if (req.jump) op = OP_JUMP;
        else if (req.ret)  op = OP_RET;
        else if (req.lowr) op = OP_LOWR;
        else if (req.step) op = OP_STEP;
        else               op = OP_HOLD;
    end
endmodule

// File: rtl/pcseq_page_latch.sv
module pcseq_page_latch #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= wdata;
    end
endmodule

// File: rtl/pcseq_ring_stack.sv
module pcseq_ring_stack #(
    parameter int unsigned W     = 13,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;
    logic [W-1:0]     slot_q [DEPTH];

    // ring arithmetic that works for any depth, not only powers of two
    assign ptr_up = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    assign ptr_dn = (ptr_q == '0) ? LAST : ptr_q - PTR_W'(1);
    assign top    = slot_q[ptr_dn];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) slot_q[i] <= '0;
        end else if (push) begin
            slot_q[ptr_q] <= push_data;
            ptr_q         <= ptr_up;
        end else if (pop) begin
            ptr_q <= ptr_dn;
        end
    end
endmodule

// File: rtl/pcseq_counter.sv
module pcseq_counter
    import pcseq_pkg::*;
#(
    parameter int unsigned PC_W    = 13,
    parameter int unsigned TGT_W   = 11,
    parameter int unsigned LOW_W   = 8,
    parameter int unsigned RST_VEC = 0,
    parameter int unsigned IRQ_VEC = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  pc_op_e                  op,
    input  logic [TGT_W-1:0]        target,
    input  logic [LOW_W-1:0]        lo_data,
    input  logic [PC_W-LOW_W-1:0]   latch,
    input  logic [PC_W-1:0]         stack_top,
    output logic [PC_W-1:0]         pc_q,
    output logic [PC_W-1:0]         push_val
);
    localparam int unsigned LATCH_W = PC_W - LOW_W;
    localparam int unsigned PAGE_W  = PC_W - TGT_W;

    logic [PC_W-1:0] pc_next;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] paged;

    assign pc_inc = pc_q + PC_W'(1);
    assign paged  = {latch[LATCH_W-1 -: PAGE_W], target};

    // interrupts save the address not yet executed, calls the next one
    assign push_val = (op == OP_IRQ) ? pc_q : pc_inc;

    always_comb begin
        unique case (op)
            OP_STEP: pc_next = pc_inc;
            OP_LOWR: pc_next = {latch, lo_data};
            OP_RET:  pc_next = stack_top;
            OP_JUMP: pc_next = paged;
            OP_CALL: pc_next = paged;
            OP_IRQ:  pc_next = PC_W'(IRQ_VEC);
            default: pc_next = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= PC_W'(RST_VEC);
        else     pc_q <= pc_next;
    end
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
    import pcseq_pkg::*;
#(
    parameter int unsigned PC_W    = DEF_PC_W,
    parameter int unsigned TGT_W   = DEF_TGT_W,
    parameter int unsigned LOW_W   = DEF_LOW_W,
    parameter int unsigned DEPTH   = DEF_DEPTH,
    parameter int unsigned MEM_AW  = DEF_MEM_AW,
    parameter int unsigned RST_VEC = DEF_RST_VEC,
    parameter int unsigned IRQ_VEC = DEF_IRQ_VEC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_i,
    input  logic                  jump_i,
    input  logic                  call_i,
    input  logic                  ret_i,
    input  logic                  irq_i,
    input  logic                  lo_wr_i,
    input  logic [LOW_W-1:0]      lo_wdata_i,
    input  logic                  latch_wr_i,
    input  logic [PC_W-LOW_W-1:0] latch_wdata_i,
    input  logic [TGT_W-1:0]      target_i,
    output logic [PC_W-1:0]       fetch_addr_o,
    output logic [MEM_AW-1:0]     mem_addr_o,
    output logic [LOW_W-1:0]      pc_lo_o
);
    localparam int unsigned LATCH_W = PC_W - LOW_W;

    strobes_t              req;
    pc_op_e                op;
    logic [LATCH_W-1:0]    latch_q;
    logic [PC_W-1:0]       pc_q;
    logic [PC_W-1:0]       push_val;
    logic [PC_W-1:0]       stack_top;

    assign req = '{irq: irq_i, call: call_i, jump: jump_i,
                   ret: ret_i, lowr: lo_wr_i, step: step_i};

    pcseq_arbiter i_arb (
        .req (req),
        .op  (op)
    );

    pcseq_page_latch #(.W(LATCH_W)) i_latch (
        .clk   (clk),
        .rst   (rst),
        .wr    (latch_wr_i),
        .wdata (latch_wdata_i),
        .q     (latch_q)
    );

    pcseq_ring_stack #(.W(PC_W), .DEPTH(DEPTH)) i_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (op_pushes(op)),
        .pop       (op_pops(op)),
        .push_data (push_val),
        .top       (stack_top)
    );

    pcseq_counter #(
        .PC_W(PC_W), .TGT_W(TGT_W), .LOW_W(LOW_W),
        .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)
    ) i_cnt (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .target    (target_i),
        .lo_data   (lo_wdata_i),
        .latch     (latch_q),
        .stack_top (stack_top),
        .pc_q      (pc_q),
        .push_val  (push_val)
    );

    assign fetch_addr_o = pc_q;
    assign pc_lo_o      = pc_q[LOW_W-1:0];

    generate
        if (MEM_AW >= PC_W) begin : g_full_mem
            assign mem_addr_o = MEM_AW'(pc_q);
        end else begin : g_wrap_mem
            assign mem_addr_o = pc_q[MEM_AW-1:0];
        end
    endgenerate
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
    parameter int unsigned PC_W    = 13,
    parameter int unsigned TGT_W   = 11,
    parameter int unsigned LOW_W   = 8,
    parameter int unsigned IRQ_VEC = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  step_i,
    input logic                  jump_i,
    input logic                  call_i,
    input logic                  ret_i,
    input logic                  irq_i,
    input logic                  lo_wr_i,
    input logic [LOW_W-1:0]      lo_wdata_i,
    input logic                  latch_wr_i,
    input logic [TGT_W-1:0]      target_i,
    input logic [PC_W-1:0]       fetch_addr_o,
    input logic [PC_W-LOW_W-1:0] latch
);
    localparam int unsigned LATCH_W = PC_W - LOW_W;
    localparam int unsigned PAGE_W  = PC_W - TGT_W;

    logic was_rst;
    always_ff @(posedge clk) was_rst <= rst;

    always @(posedge clk) begin
        if (was_rst && !rst) begin
            assert_reset_zero_R1: assert (fetch_addr_o == '0 && latch == '0)
                else $error("R1: counter or latch not cleared by reset");
        end
    end

    assert_step_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (step_i && !irq_i && !call_i && !jump_i && !ret_i && !lo_wr_i)
        |=> fetch_addr_o == PC_W'($past(fetch_addr_o) + PC_W'(1)));

    assert_lowr_load_R3: assert property (@(posedge clk) disable iff (rst)
        (lo_wr_i && !irq_i && !call_i && !jump_i && !ret_i)
        |=> fetch_addr_o == {$past(latch), $past(lo_wdata_i)});

    assert_jump_page_R4: assert property (@(posedge clk) disable iff (rst)
        (jump_i && !irq_i && !call_i)
        |=> fetch_addr_o == {$past(latch[LATCH_W-1 -: PAGE_W]), $past(target_i)});

    assert_call_target_R5: assert property (@(posedge clk) disable iff (rst)
        (call_i && !irq_i)
        |=> fetch_addr_o[TGT_W-1:0] == $past(target_i));

    assert_irq_vector_R7: assert property (@(posedge clk) disable iff (rst)
        irq_i |=> fetch_addr_o == PC_W'(IRQ_VEC));

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !latch_wr_i |=> $stable(latch));
endmodule

bind fetch_addr_gen pcseq_checker #(
    .PC_W(PC_W), .TGT_W(TGT_W), .LOW_W(LOW_W), .IRQ_VEC(IRQ_VEC)
) i_pcseq_checker (
    .clk          (clk),
    .rst          (rst),
    .step_i       (step_i),
    .jump_i       (jump_i),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .irq_i        (irq_i),
    .lo_wr_i      (lo_wr_i),
    .lo_wdata_i   (lo_wdata_i),
    .latch_wr_i   (latch_wr_i),
    .target_i     (target_i),
    .fetch_addr_o (fetch_addr_o),
    .latch        (latch_q)
);

// File: tb/test_fetch_addr_gen.sv
module test_fetch_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_i = 0, jump_i = 0, call_i = 0, ret_i = 0, irq_i = 0;
    logic        lo_wr_i = 0, latch_wr_i = 0;
    logic [7:0]  lo_wdata_i = '0;
    logic [4:0]  latch_wdata_i = '0;
    logic [10:0] target_i = '0;
    logic [12:0] fetch_addr_o;
    logic [9:0]  mem_addr_o;
    logic [7:0]  pc_lo_o;

    int checks = 0;
    int failures = 0;

    // reference state
    logic [12:0] m_pc = '0;
    logic [4:0]  m_latch = '0;
    logic [12:0] m_stk [8];
    int          m_sp = 0;

    always #2 clk = ~clk;

    fetch_addr_gen i_fetch_addr_gen (
        .clk(clk), .rst(rst), .step_i(step_i), .jump_i(jump_i), .call_i(call_i),
        .ret_i(ret_i), .irq_i(irq_i), .lo_wr_i(lo_wr_i), .lo_wdata_i(lo_wdata_i),
        .latch_wr_i(latch_wr_i), .latch_wdata_i(latch_wdata_i), .target_i(target_i),
        .fetch_addr_o(fetch_addr_o), .mem_addr_o(mem_addr_o), .pc_lo_o(pc_lo_o)
    );

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic m_push(input logic [12:0] v);
        m_stk[m_sp] = v;
        m_sp = (m_sp + 1) % 8;
    endtask

    function automatic logic [12:0] m_pop();
        m_sp = (m_sp + 7) % 8;
        return m_stk[m_sp];
    endfunction

    // one cycle: drive at falling edge, model, sample at the next falling edge
    task automatic cyc(input string req, input logic s, input logic j, input logic c,
                       input logic r, input logic q, input logic lw, input logic [7:0] ld,
                       input logic aw, input logic [4:0] ad, input logic [10:0] t);
        step_i = s; jump_i = j; call_i = c; ret_i = r; irq_i = q;
        lo_wr_i = lw; lo_wdata_i = ld; latch_wr_i = aw; latch_wdata_i = ad; target_i = t;
        @(negedge clk);
        if (q)       begin m_push(m_pc); m_pc = 13'h0004; end
        else if (c)  begin m_push(m_pc + 13'd1); m_pc = {m_latch[4:3], t}; end
        else if (j)  m_pc = {m_latch[4:3], t};
        else if (r)  m_pc = m_pop();
        else if (lw) m_pc = {m_latch, ld};
        else if (s)  m_pc = m_pc + 13'd1;
        if (aw) m_latch = ad;
        step_i = 0; jump_i = 0; call_i = 0; ret_i = 0; irq_i = 0;
        lo_wr_i = 0; latch_wr_i = 0;
        check(req, fetch_addr_o, m_pc);
        check("R10", {3'b0, mem_addr_o}, {3'b0, m_pc[9:0]});
        check("R3 low byte", {5'b0, pc_lo_o}, {5'b0, m_pc[7:0]});
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0713));
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        @(negedge clk); @(negedge clk);
        check("R1 during reset", fetch_addr_o, 13'h0000);
        rst = 0;
        @(negedge clk);
        check("R1 after reset", fetch_addr_o, 13'h0000);
        // R1: return right after reset restores zero
        cyc("R1 ret after reset", 0,0,0,1,0, 0,8'h00, 0,5'h00, 11'h0);

        // R3 load latch then low byte, R2 wrap past 1FFF
        cyc("R8 latch write", 0,0,0,0,0, 0,8'h00, 1,5'h1F, 11'h0);
        cyc("R3", 0,0,0,0,0, 1,8'hFF, 0,5'h00, 11'h0);
        cyc("R2 wrap", 1,0,0,0,0, 0,8'h00, 0,5'h00, 11'h0);
        cyc("R2", 1,0,0,0,0, 0,8'h00, 0,5'h00, 11'h0);

        // R4 page insertion: latch bits 4:3 = 11
        cyc("R8 latch write", 0,0,0,0,0, 0,8'h00, 1,5'h18, 11'h0);
        cyc("R4", 0,1,0,0,0, 0,8'h00, 0,5'h00, 11'h123);

        // R11 irq wins over call; R7 vector; R6 restore
        cyc("R11 R7 irq over call", 0,0,1,0,1, 0,8'h00, 0,5'h00, 11'h055);
        cyc("R5 call", 0,0,1,0,0, 0,8'h00, 0,5'h00, 11'h200);
        cyc("R6 ret of call", 0,0,0,1,0, 0,8'h00, 0,5'h00, 11'h0);
        cyc("R6 ret of irq", 0,0,0,1,0, 0,8'h00, 0,5'h00, 11'h0);
        // R11 jump beats return and step
        cyc("R11 jump over ret", 1,1,0,1,0, 1,8'h33, 0,5'h00, 11'h07A);

        // R9 ring: nine calls, nine returns
        cyc("R8 latch write", 0,0,0,0,0, 0,8'h00, 1,5'h08, 11'h0);
        for (int k = 1; k <= 9; k++)
            cyc("R9 push", 0,0,1,0,0, 0,8'h00, 0,5'h00, 11'(k * 16));
        for (int k = 1; k <= 9; k++)
            cyc("R9 pop", 0,0,0,1,0, 0,8'h00, 0,5'h00, 11'h0);
        // R8: latch untouched by the stack traffic above
        cyc("R8 after stack", 0,0,0,0,0, 1,8'h5A, 0,5'h00, 11'h0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int unsigned r = $urandom % 100;
            logic [7:0]  ld = 8'($urandom);
            logic [4:0]  ad = 5'($urandom);
            logic [10:0] t  = 11'($urandom);
            logic aw = ($urandom % 4) == 0;
            if (r < 30)      cyc("R2 rnd", 1,0,0,0,0, 0,ld, aw,ad, t);
            else if (r < 42) cyc("R4 rnd", 0,1,0,0,0, 0,ld, aw,ad, t);
            else if (r < 56) cyc("R5 rnd", 0,0,1,0,0, 0,ld, aw,ad, t);
            else if (r < 72) cyc("R6 rnd", 0,0,0,1,0, 0,ld, aw,ad, t);
            else if (r < 78) cyc("R7 rnd", 0,0,0,0,1, 0,ld, aw,ad, t);
            else if (r < 88) cyc("R3 rnd", 0,0,0,0,0, 1,ld, aw,ad, t);
            else             cyc("R11 rnd", r[0],r[1],r[2],r[3],(r % 7) == 0,
                                 r[4],ld, aw,ad, t);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end
endmodule